// File: doc/BRIEF.md
# Two-Level Prioritized Interrupt Controller

This block gathers interrupt requests for a small 8-bit processor core. It serves two external pins, timers 0 and 1, a timer 2 with two event causes, and a serial port with receive and transmit events. It holds one flag per event. Each source is qualified by its own enable bit and by a master enable. A priority register places every source in a high or a low level. The controller presents the highest-ranked eligible source to the core as a request, with a source number and a vector address.

The core answers with a one-cycle acknowledge, which marks that level as in service. On the same acknowledge the controller clears the flags that hardware owns: the timer 0 and timer 1 rollover flags, and an external flag only when its pin is in edge mode. The serial flags and the timer-2 flags stay set until software clears them. A return strobe from the core ends the innermost active service. The core reads and writes all registers through a byte-wide special-function-register port.

Register addresses are parameters. They default to: enable 0xA8, priority 0xB8, flags 0xC0, pin mode 0xC1.

Top module: `pirq_top`

## Requirements
- R1: After reset the enable, priority, flag and mode registers all read 0 and `irq_req_o` is low.
- R2: With mode bit g = 1 (bit 0 for pin 0, bit 1 for pin 1), pin g is in edge mode. A pin sampled high and then low sets its flag, which reads back two clocks after the pin falls. Flag bit 0 belongs to pin 0 and flag bit 2 to pin 1. Keeping the pin low does not set the flag again. Acknowledging that source's vector clears the flag.
- R3: With mode bit g = 0, the pin's flag tracks the inverted pin, two clocks late. Neither an acknowledge nor a software write changes that flag.
- R4: A one-cycle rollover strobe on `tmr_ovf_i[0]` sets flag bit 1, and one on `tmr_ovf_i[1]` sets flag bit 3. The flag reads back on the next clock. Acknowledging that timer's vector clears the flag.
- R5: The serial source requests while flag bit 4 (receive) or flag bit 5 (transmit) is set. Timer 2 requests while flag bit 6 (overflow) or flag bit 7 (external) is set. An acknowledge leaves all four of these flags unchanged.
- R6: A software write to the flag register sets and clears flags, so it raises new requests and cancels pending ones.
- R7: The enable register holds the source enables in bits 0..5: ext0, tmr0, ext1, tmr1, serial, timer 2. Bit 7 is the master enable. While bit 7 is 0, or while a source's own enable bit is 0, that source raises no request.
- R8: Priority register bits 0..5 use the same source order as the enable register, and a 1 puts the source in the high level. An eligible high-level source is presented before any low-level source.
- R9: Within a level, the lowest source number wins. The numbers are ext0 = 0, tmr0 = 1, ext1 = 2, tmr1 = 3, serial = 4, timer 2 = 5. The vector is 0x0003 + 8 × the source number.
- R10: While a low-level service is active, only a high-level source may be presented. While a high-level service is active, nothing is presented.
- R11: `irq_reti_i` clears the high-level service mark if it is set, and otherwise the low-level mark.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_pin_n_i | input | 2 | Active-low external request pins |
| tmr_ovf_i | input | 2 | Rollover strobes of timers 0 and 1 |
| ser_rx_i | input | 1 | Serial receive-done strobe |
| ser_tx_i | input | 1 | Serial transmit-done strobe |
| t2_ovf_i | input | 1 | Timer 2 overflow strobe |
| t2_ext_i | input | 1 | Timer 2 external-event strobe |
| sfr_wr_i | input | 1 | Register write strobe |
| sfr_addr_i | input | 8 | Register address |
| sfr_wdata_i | input | 8 | Register write data |
| sfr_rdata_o | output | 8 | Register read data (combinational) |
| irq_req_o | output | 1 | Vector request to the core |
| irq_id_o | output | 3 | Number of the presented source |
| irq_vec_o | output | 16 | Vector address of the presented source |
| irq_ack_i | input | 1 | Core takes the presented vector |
| irq_reti_i | input | 1 | Core returns from a service routine |

## Verification
A wrong service mark shows up at once as a missing request or an extra one. After a return strobe, a stuck high-level mark keeps `irq_req_o` low even though an eligible flag is pending. A low-level mark that was never set lets a second low-level source through right after an acknowledge. A flag cleared when it should not be, or left set when it should be cleared, shows up in the flag register one clock after the acknowledge. It also shows up as a vector that reappears or goes missing after the next return strobe. An edge detector that re-arms while the pin is held low shows up as a fresh flag two clocks later.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
   localparam int NSRC = 6;
   localparam int ID_W = $clog2(NSRC);
   localparam int FLG_W = 8;
   localparam int NEXT = 2;

   typedef logic [ID_W-1:0] src_id_t;

   localparam src_id_t SRC_EXT0 = 3'd0;
   localparam src_id_t SRC_TMR0 = 3'd1;
   localparam src_id_t SRC_EXT1 = 3'd2;
   localparam src_id_t SRC_TMR1 = 3'd3;
   localparam src_id_t SRC_SER  = 3'd4;
   localparam src_id_t SRC_TM2  = 3'd5;
endpackage

// File: rtl/pirq_pick.sv
module pirq_pick #(
   parameter int W = 6,
   localparam int IW = (W > 1) ? $clog2(W) : 1
) (
   input  logic [W-1:0]  req_i,
   output logic          any_o,
   output logic [IW-1:0] idx_o
);
   logic [W:0]   seen;
   logic [W-1:0] first;

   assign seen[0] = 1'b0;
   for (genvar gi = 0; gi < W; gi++) begin : g_chain
      assign first[gi]  = req_i[gi] & ~seen[gi];
      assign seen[gi+1] = seen[gi] | req_i[gi];
   end

   assign any_o = seen[W];

   always_comb begin
      idx_o = '0;
      for (int i = 0; i < W; i++)
         if (first[i]) idx_o = idx_o | IW'(i);
   end
endmodule

// File: rtl/pirq_flags.sv
module pirq_flags
   import pirq_pkg::*;
#(
   parameter int              ADDR_W    = 8,
   parameter logic [ADDR_W-1:0] FLAG_ADDR = 8'hC0,
   parameter logic [ADDR_W-1:0] MODE_ADDR = 8'hC1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NEXT-1:0]   ext_pin_n_i,
   input  logic [1:0]        tmr_ovf_i,
   input  logic              ser_rx_i,
   input  logic              ser_tx_i,
   input  logic              t2_ovf_i,
   input  logic              t2_ext_i,
   input  logic              sfr_wr_i,
   input  logic [ADDR_W-1:0] sfr_addr_i,
   input  logic [FLG_W-1:0]  sfr_wdata_i,
   input  logic              ack_i,
   input  src_id_t           ack_id_i,
   output logic [FLG_W-1:0]  flags_o,
   output logic [NEXT-1:0]   mode_o,
   output logic [NSRC-1:0]   src_req_o
);
   logic [NEXT-1:0]  pin_q, pin_d, ext_fall;
   logic [FLG_W-1:0] flg_q, flg_nxt;
   logic [NEXT-1:0]  mode_q;
   logic             wr_flg, wr_mode;

   assign wr_flg  = sfr_wr_i && (sfr_addr_i == FLAG_ADDR);
   assign wr_mode = sfr_wr_i && (sfr_addr_i == MODE_ADDR);

   for (genvar g = 0; g < NEXT; g++) begin : g_ext
      assign ext_fall[g] = pin_d[g] & ~pin_q[g];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pin_q  <= '1;
         pin_d  <= '1;
         mode_q <= '0;
      end else begin
         pin_q <= ext_pin_n_i;
         pin_d <= pin_q;
         if (wr_mode) mode_q <= sfr_wdata_i[NEXT-1:0];
      end
   end

   always_comb begin
      flg_nxt = flg_q;
      if (wr_flg) flg_nxt = sfr_wdata_i;
      if (ack_i) begin
         for (int g = 0; g < NEXT; g++) begin
            if (ack_id_i == src_id_t'(2*g) && mode_q[g]) flg_nxt[2*g]   = 1'b0;
            if (ack_id_i == src_id_t'(2*g+1))             flg_nxt[2*g+1] = 1'b0;
         end
      end
      for (int g = 0; g < NEXT; g++) begin
         flg_nxt[2*g+1] = flg_nxt[2*g+1] | tmr_ovf_i[g];
         if (mode_q[g]) flg_nxt[2*g] = flg_nxt[2*g] | ext_fall[g];
         else           flg_nxt[2*g] = ~pin_q[g];
      end
      flg_nxt[4] = flg_nxt[4] | ser_rx_i;
      flg_nxt[5] = flg_nxt[5] | ser_tx_i;
      flg_nxt[6] = flg_nxt[6] | t2_ovf_i;
      flg_nxt[7] = flg_nxt[7] | t2_ext_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flg_q <= '0;
      else        flg_q <= flg_nxt;
   end

   assign flags_o   = flg_q;
   assign mode_o    = mode_q;
   assign src_req_o = {flg_q[6] | flg_q[7], flg_q[4] | flg_q[5],
                       flg_q[3], flg_q[2], flg_q[1], flg_q[0]};

   a_r4_tmr_set: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_ovf_i[0] |=> flags_o[1]);
   a_r4_tmr_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && ack_id_i == SRC_TMR1 && !wr_flg && !tmr_ovf_i[1]) |=> !flags_o[3]);
   a_r2_edge_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && ack_id_i == SRC_EXT0 && mode_o[0] && !wr_flg && !ext_fall[0]) |=> !flags_o[0]);
   a_r5_ser_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && ack_id_i == SRC_SER && !wr_flg && flags_o[4]) |=> flags_o[4]);
   a_r5_t2_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && ack_id_i == SRC_TM2 && !wr_flg && flags_o[7]) |=> flags_o[7]);
endmodule

// File: rtl/pirq_arb.sv
module pirq_arb
   import pirq_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] en_req_i,
   input  logic [NSRC-1:0] prio_i,
   input  logic            ack_i,
   input  logic            reti_i,
   output logic            irq_req_o,
   output src_id_t         irq_id_o
);
   logic [NSRC-1:0] hi_set, lo_set;
   logic            hi_any, lo_any, hi_act_q, lo_act_q, sel_hi;
   src_id_t         hi_idx, lo_idx;

   assign hi_set = en_req_i & prio_i;
   assign lo_set = en_req_i & ~prio_i;

   pirq_pick #(.W(NSRC)) u_pick_hi (.req_i(hi_set), .any_o(hi_any), .idx_o(hi_idx));
   pirq_pick #(.W(NSRC)) u_pick_lo (.req_i(lo_set), .any_o(lo_any), .idx_o(lo_idx));

   assign sel_hi    = hi_any && !hi_act_q;
   assign irq_req_o = sel_hi || (lo_any && !hi_act_q && !lo_act_q);
   assign irq_id_o  = sel_hi ? hi_idx : lo_idx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_act_q <= 1'b0;
         lo_act_q <= 1'b0;
      end else begin
         if (reti_i) begin
            if (hi_act_q) hi_act_q <= 1'b0;
            else          lo_act_q <= 1'b0;
         end
         if (ack_i && irq_req_o) begin
            if (sel_hi) hi_act_q <= 1'b1;
            else        lo_act_q <= 1'b1;
         end
      end
   end

   a_r10_hi_blocks_all: assert property (@(posedge clk) disable iff (!rst_n)
      hi_act_q |-> !irq_req_o);
   a_r10_lo_only_hi: assert property (@(posedge clk) disable iff (!rst_n)
      (lo_act_q && irq_req_o) |-> prio_i[irq_id_o]);
   a_r8_hi_first: assert property (@(posedge clk) disable iff (!rst_n)
      ((|hi_set) && !hi_act_q) |-> (irq_req_o && prio_i[irq_id_o]));
   a_r11_reti_hi: assert property (@(posedge clk) disable iff (!rst_n)
      (reti_i && hi_act_q && !ack_i) |=> !hi_act_q);
   a_r9_id_valid: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req_o |-> en_req_i[irq_id_o]);
endmodule

// File: rtl/pirq_top.sv
module pirq_top
   import pirq_pkg::*;
#(
   parameter int                ADDR_W    = 8,
   parameter logic [ADDR_W-1:0] IE_ADDR   = 8'hA8,
   parameter logic [ADDR_W-1:0] IP_ADDR   = 8'hB8,
   parameter logic [ADDR_W-1:0] FLAG_ADDR = 8'hC0,
   parameter logic [ADDR_W-1:0] MODE_ADDR = 8'hC1,
   parameter int                VEC_W     = 16,
   parameter int                VEC_BASE  = 3,
   parameter int                VEC_STEP  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        ext_pin_n_i,
   input  logic [1:0]        tmr_ovf_i,
   input  logic              ser_rx_i,
   input  logic              ser_tx_i,
   input  logic              t2_ovf_i,
   input  logic              t2_ext_i,
   input  logic              sfr_wr_i,
   input  logic [ADDR_W-1:0] sfr_addr_i,
   input  logic [7:0]        sfr_wdata_i,
   output logic [7:0]        sfr_rdata_o,
   output logic              irq_req_o,
   output logic [2:0]        irq_id_o,
   output logic [VEC_W-1:0]  irq_vec_o,
   input  logic              irq_ack_i,
   input  logic              irq_reti_i
);
   localparam int EA_BIT  = 7;
   localparam int VEC_TOP = VEC_BASE + VEC_STEP * (NSRC - 1);

   if (VEC_TOP >= (1 << VEC_W)) begin : g_bad_vec
      $error("vector range does not fit VEC_W");
   end
   if (IE_ADDR == IP_ADDR || IE_ADDR == FLAG_ADDR || IE_ADDR == MODE_ADDR ||
       IP_ADDR == FLAG_ADDR || IP_ADDR == MODE_ADDR || FLAG_ADDR == MODE_ADDR) begin : g_bad_addr
      $error("register addresses must be distinct");
   end

   logic [7:0]      ie_q, flags;
   logic [NSRC-1:0] ip_q, src_req, en_req;
   logic [NEXT-1:0] mode;
   src_id_t         id;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ie_q <= '0;
         ip_q <= '0;
      end else if (sfr_wr_i) begin
         if (sfr_addr_i == IE_ADDR) ie_q <= sfr_wdata_i & 8'hBF;
         if (sfr_addr_i == IP_ADDR) ip_q <= sfr_wdata_i[NSRC-1:0];
      end
   end

   pirq_flags #(.ADDR_W(ADDR_W), .FLAG_ADDR(FLAG_ADDR), .MODE_ADDR(MODE_ADDR)) u_flags (
      .clk(clk), .rst_n(rst_n), .ext_pin_n_i(ext_pin_n_i), .tmr_ovf_i(tmr_ovf_i),
      .ser_rx_i(ser_rx_i), .ser_tx_i(ser_tx_i), .t2_ovf_i(t2_ovf_i), .t2_ext_i(t2_ext_i),
      .sfr_wr_i(sfr_wr_i), .sfr_addr_i(sfr_addr_i), .sfr_wdata_i(sfr_wdata_i),
      .ack_i(irq_ack_i && irq_req_o), .ack_id_i(id),
      .flags_o(flags), .mode_o(mode), .src_req_o(src_req));

   assign en_req = src_req & ie_q[NSRC-1:0] & {NSRC{ie_q[EA_BIT]}};

   pirq_arb u_arb (
      .clk(clk), .rst_n(rst_n), .en_req_i(en_req), .prio_i(ip_q),
      .ack_i(irq_ack_i), .reti_i(irq_reti_i), .irq_req_o(irq_req_o), .irq_id_o(id));

   assign irq_id_o  = id;
   assign irq_vec_o = VEC_W'(VEC_BASE) + VEC_W'(id) * VEC_W'(VEC_STEP);

   always_comb begin
      sfr_rdata_o = '0;
      if (sfr_addr_i == IE_ADDR)   sfr_rdata_o = ie_q;
      if (sfr_addr_i == IP_ADDR)   sfr_rdata_o = {2'b00, ip_q};
      if (sfr_addr_i == FLAG_ADDR) sfr_rdata_o = flags;
      if (sfr_addr_i == MODE_ADDR) sfr_rdata_o = {6'b0, mode};
   end

   a_r7_master_mask: assert property (@(posedge clk) disable iff (!rst_n)
      !ie_q[EA_BIT] |-> !irq_req_o);
   a_r7_src_mask: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req_o |-> ie_q[irq_id_o]);
endmodule

// File: tb/pirq_top_tb.sv
module pirq_top_tb;
   localparam int CLK_PERIOD = 10;
   localparam logic [7:0] A_IE = 8'hA8, A_IP = 8'hB8, A_FL = 8'hC0, A_MD = 8'hC1;

   logic clk = 0, rst_n = 0;
   logic [1:0] pin_n = 2'b11, tovf = 0;
   logic rx = 0, tx = 0, t2o = 0, t2e = 0;
   logic wr = 0;
   logic [7:0] addr = 0, wdata = 0, rdata;
   logic req, ack = 0, reti = 0;
   logic [2:0] id;
   logic [15:0] vec;
   int n_chk = 0, n_fail = 0;
   bit done = 0;
   int q_id[$];
   string q_tag[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   pirq_top u_dut (
      .clk(clk), .rst_n(rst_n), .ext_pin_n_i(pin_n), .tmr_ovf_i(tovf),
      .ser_rx_i(rx), .ser_tx_i(tx), .t2_ovf_i(t2o), .t2_ext_i(t2e),
      .sfr_wr_i(wr), .sfr_addr_i(addr), .sfr_wdata_i(wdata), .sfr_rdata_o(rdata),
      .irq_req_o(req), .irq_id_o(id), .irq_vec_o(vec),
      .irq_ack_i(ack), .irq_reti_i(reti));

   task automatic chk(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic tick(int n = 1);
      repeat (n) begin @(posedge clk); #1; end
   endtask

   task automatic wr_reg(logic [7:0] a, logic [7:0] d);
      addr = a; wdata = d; wr = 1; tick(); wr = 0;
   endtask

   function automatic int rd(logic [7:0] a);
      addr = a;
      return 0;
   endfunction

   task automatic rd_reg(logic [7:0] a, output logic [7:0] d);
      addr = a; #1; d = rdata;
   endtask

   task automatic take(int exp_id, string tag);
      q_id.push_back(exp_id); q_tag.push_back(tag);
      ack = 1; tick(); ack = 0;
   endtask

   task automatic do_reti();
      reti = 1; tick(); reti = 0;
   endtask

   always @(negedge clk) begin
      if (ack) begin
         if (q_id.size() == 0) begin
            chk("scoreboard empty", 1, 0);
         end else begin
            automatic int e = q_id.pop_front();
            automatic string t = q_tag.pop_front();
            chk({t, " req"}, int'(req), 1);
            chk({t, " id"}, int'(id), e);
            chk({t, " vec R9"}, int'(vec), 3 + 8 * e);
         end
      end
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         n_fail++; n_chk++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [7:0] d;
      void'(rd(A_IE));
      tick(3); rst_n = 1; tick();
      // R1 reset state
      chk("R1 req", int'(req), 0);
      rd_reg(A_IE, d); chk("R1 enable", d, 0);
      rd_reg(A_IP, d); chk("R1 priority", d, 0);
      rd_reg(A_FL, d); chk("R1 flags", d, 0);
      rd_reg(A_MD, d); chk("R1 mode", d, 0);

      // R2 edge mode on pin 0
      wr_reg(A_MD, 8'h01); wr_reg(A_IE, 8'h81);
      pin_n[0] = 0; tick(2);
      rd_reg(A_FL, d); chk("R2 edge sets flag", d[0], 1);
      take(0, "R2 ext0 vector");
      rd_reg(A_FL, d); chk("R2 ack clears edge flag", d[0], 0);
      chk("R10 lo active blocks", int'(req), 0);
      do_reti(); tick(3);
      rd_reg(A_FL, d); chk("R2 held low no retrigger", d[0], 0);
      pin_n[0] = 1; tick(2);

      // R3 level mode on pin 1
      wr_reg(A_IE, 8'h84);
      pin_n[1] = 0; tick(2);
      rd_reg(A_FL, d); chk("R3 level flag set", d[2], 1);
      take(2, "R3 ext1 vector");
      rd_reg(A_FL, d); chk("R3 ack keeps level flag", d[2], 1);
      do_reti();
      wr_reg(A_FL, 8'h00);
      rd_reg(A_FL, d); chk("R3 write ignored", d[2], 1);
      pin_n[1] = 1; tick(2);
      rd_reg(A_FL, d); chk("R3 flag follows pin high", d[2], 0);

      // R4 timer 0
      wr_reg(A_IE, 8'h82);
      tovf[0] = 1; tick(); tovf[0] = 0;
      rd_reg(A_FL, d); chk("R4 rollover sets flag", d[1], 1);
      take(1, "R4 tmr0 vector");
      rd_reg(A_FL, d); chk("R4 ack clears timer flag", d[1], 0);
      do_reti();

      // R5 / R6 serial
      wr_reg(A_IE, 8'h90);
      rx = 1; tick(); rx = 0;
      take(4, "R5 serial vector");
      rd_reg(A_FL, d); chk("R5 rx flag kept", d[4], 1);
      do_reti();
      chk("R5 serial still requests", int'(req), 1);
      wr_reg(A_FL, 8'h00);
      chk("R6 software cancel", int'(req), 0);
      wr_reg(A_FL, 8'h20);
      chk("R6 software raise", int'(req), 1);
      chk("R6 raise id", int'(id), 4);
      wr_reg(A_FL, 8'h00);

      // R9 polling order
      wr_reg(A_IE, 8'hBF);
      wr_reg(A_FL, 8'h4A);
      chk("R9 lowest wins", int'(id), 1);
      take(1, "R9 first");
      chk("R10 second low held", int'(req), 0);
      do_reti();
      take(3, "R9 second");
      do_reti();
      take(5, "R9 third");
      do_reti();
      rd_reg(A_FL, d); chk("R5 t2 flag kept", d, 8'h40);
      wr_reg(A_FL, 8'h00);

      // R8 / R10 / R11 priority
      wr_reg(A_IP, 8'h20);
      wr_reg(A_FL, 8'h82);
      chk("R8 high level first", int'(id), 5);
      take(5, "R8 t2 high");
      chk("R10 high blocks all", int'(req), 0);
      do_reti();
      chk("R5 t2 re-requests id", int'(id), 5);
      wr_reg(A_FL, 8'h02);
      take(1, "R10 low service");
      wr_reg(A_FL, 8'h40);
      chk("R10 high preempts low", int'(id), 5);
      take(5, "R10 preempt");
      wr_reg(A_FL, 8'h00);
      do_reti();
      wr_reg(A_FL, 8'h08);
      chk("R11 low mark survives", int'(req), 0);
      do_reti();
      chk("R11 low mark cleared", int'(req), 1);
      take(3, "R11 tmr1");
      do_reti();

      // R7 masking
      wr_reg(A_IP, 8'h00);
      wr_reg(A_IE, 8'h3F);
      wr_reg(A_FL, 8'h08);
      chk("R7 master off", int'(req), 0);
      wr_reg(A_IE, 8'hB7);
      chk("R7 source off", int'(req), 0);
      wr_reg(A_IE, 8'hBF);
      chk("R7 master on", int'(req), 1);
      chk("R7 id", int'(id), 3);
      tick(2);
      chk("scoreboard drained", q_id.size(), 0);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule